// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital half of a 12-bit successive approximation converter. A one-cycle start strobe from the surrounding bus control logic is accepted only when the block is idle. When it is accepted, the block raises a hold signal that freezes the sampled analog input. It then walks a trial code from the most significant bit down to the least significant bit. An external DAC turns each trial code into a level, and a comparator returns one bit that says whether that level is above the held input.

After the last decision, the finished code is written into the result latch and hold is released, so the input is tracked again. One cycle later, busy falls and a one-cycle done pulse marks the result as valid. A configurable acquisition window then has to pass before another start is accepted. The conversion time and the acquisition window together set the throughput period.

Top module: `sar_conv_sequencer`

## Requirements
- R1: While reset is low at a clock edge, hold_o, busy_o and done_o go low, and trial_o and result_o go to zero.
- R2: When start_i is high at a clock edge in the idle state, the next cycle shows hold_o=1, busy_o=1 and trial_o=0x800. The input held is the one tracked up to that edge.
- R3: Bits are resolved from bit 11 down to bit 0. Each bit step lasts CLKS_PER_BIT cycles. At the decision edge that ends a step, the bit under trial is cleared if cmp_i=1 (DAC level above the held input) and kept if cmp_i=0, and the next lower bit is set.
- R4: hold_o stays high for exactly 12*CLKS_PER_BIT cycles after the start edge. Input changes during that time do not reach the result.
- R5: At the final decision edge, result_o takes the finished code and hold_o falls, while busy_o is still high.
- R6: One cycle after R5, busy_o falls and done_o is high for exactly one cycle, with result_o already valid.
- R7: A start that arrives while a conversion is running is ignored and is not queued.
- R8: After the done edge, the block stays in acquisition for ACQ_CLKS cycles. Starts seen at those edges are ignored and are not queued. The earliest start accepted is at the next edge, which gives a throughput period of 12*CLKS_PER_BIT+ACQ_CLKS+2 cycles.
- R9: With an ideal comparator, the result is floor(vin*4096/full_scale) in straight binary, clamped to 0xFFF. Zero input gives 0x000 and full scale gives 0xFFF.
- R10: result_o keeps its value until the final decision edge of the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion start strobe from bus control |
| cmp_i | input | 1 | Comparator: 1 when the DAC level is above the held input |
| hold_o | output | 1 | 1 = hold the sampled input, 0 = track |
| busy_o | output | 1 | High from the accepted start until completion |
| done_o | output | 1 | One-cycle completion and data-valid strobe |
| trial_o | output | 12 | Trial code driven to the DAC |
| result_o | output | 12 | Latched conversion result |

## Verification
The bench builds the block with CLKS_PER_BIT=3 and ACQ_CLKS=4. Three clocks per step keep the comparator decision apart from the cycle in which a bit is set, so a decision taken on the wrong cycle or at the wrong bit shows up in the trial code that the bench checks after every step. The short acquisition window lets back-to-back conversions hit the first cycle at which a start is accepted. It also lets a start held high across the whole window be checked for being both ignored and not queued. An ideal comparator model reaches the zero, one-LSB, mid-scale, full-scale and over-range codes.

// File: rtl/sar_seq_pkg.sv
// Shared types for the successive approximation sequencer.
// Assumes: nothing beyond the standard language.
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,  // idle, input tracked, start accepted
        ST_CONV  = 2'd1,  // bit search under hold
        ST_XFER  = 2'd2,  // result latched, hold released, busy still high
        ST_ACQ   = 2'd3   // acquisition window, starts ignored
    } sar_state_e;
endpackage

// File: rtl/sar_step_timer.sv
// Counts clocks inside one bit step and flags the decision cycle.
// Assumes: clear and run are never high together; CLKS_PER_BIT >= 1.
module sar_step_timer #(
    parameter int CLKS_PER_BIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic step_end
);
    localparam int            CW   = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Decision cycle is the last clock of a step.
    assign step_end = run && (cnt == LAST);

    // Step clock counter, wraps at the end of every step.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clear)    cnt <= '0;
        else if (run)      cnt <= step_end ? '0 : cnt + 1'b1;
    end

    // R3
    step_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/sar_bit_engine.sv
// Holds the trial code and a one-hot pointer to the bit under trial.
// Set on load: MSB only. On each decision: clear current bit if cmp,
// set the next lower bit. Assumes decide only while the pointer is non-zero.
module sar_bit_engine #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] code_next_o,
    output logic             last_o
);
    localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] ptr;
    logic [NBITS-1:0] ptr_n;
    logic [NBITS-1:0] trial_n;

    // Pointer advances one bit toward the LSB per decision.
    assign ptr_n  = ptr >> 1;
    assign last_o = ptr[0];

    // Per-bit next value: decide the current bit, arm the next one.
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign trial_n[i] = ptr[i] ? ~cmp_i : (ptr_n[i] | trial_o[i]);
    end

    assign code_next_o = trial_n;

    // Trial code and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            trial_o <= '0;
        end else if (load) begin
            ptr     <= MSB_ONE;
            trial_o <= MSB_ONE;
        end else if (decide) begin
            ptr     <= ptr_n;
            trial_o <= trial_n;
        end
    end

    // R3
    ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr));
    // R3
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != '0) |-> ((trial_o & (ptr - 1'b1)) == '0));
    // R3
    decide_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> (ptr != '0));
endmodule

// File: rtl/sar_ctrl_fsm.sv
// Control sequence: track, convert under hold, transfer, acquisition.
// Assumes the step timer flags the decision cycle and the bit engine
// flags the LSB step. ACQ_CLKS >= 1.
module sar_ctrl_fsm
    import sar_seq_pkg::*;
#(
    parameter int ACQ_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_end,
    input  logic last_bit,
    output logic load_o,
    output logic run_o,
    output logic xfer_o,
    output logic hold_o,
    output logic busy_o,
    output logic done_o
);
    localparam int            AW       = $clog2(ACQ_CLKS + 1);
    localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_CLKS - 1);

    sar_state_e    state;
    logic [AW-1:0] acq_cnt;

    // Start is taken only from the idle state; otherwise dropped.
    assign load_o = (state == ST_TRACK) && start_i;
    assign run_o  = (state == ST_CONV);
    assign xfer_o = run_o && step_end && last_bit;

    // Sequence state, hold, busy, done and acquisition counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_TRACK;
            hold_o  <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
            acq_cnt <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_TRACK: if (start_i) begin
                    state  <= ST_CONV;
                    hold_o <= 1'b1;
                    busy_o <= 1'b1;
                end
                ST_CONV: if (xfer_o) begin
                    state  <= ST_XFER;
                    hold_o <= 1'b0;
                end
                ST_XFER: begin
                    state   <= ST_ACQ;
                    busy_o  <= 1'b0;
                    done_o  <= 1'b1;
                    acq_cnt <= '0;
                end
                ST_ACQ: begin
                    if (acq_cnt == ACQ_LAST) state <= ST_TRACK;
                    else                     acq_cnt <= acq_cnt + 1'b1;
                end
                default: state <= ST_TRACK;
            endcase
        end
    end

    // R2
    hold_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(state == ST_TRACK) && $past(start_i));
    // R8
    acq_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACQ) |=> !hold_o);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sar_result_latch.sv
// Output latch for the finished code; loads only at the final decision.
// Assumes load is a single-cycle pulse per conversion.
module sar_result_latch #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] code_i,
    output logic [NBITS-1:0] result_o
);
    // Capture the finished code.
    always_ff @(posedge clk) begin
        if (!rst_n)    result_o <= '0;
        else if (load) result_o <= code_i;
    end

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> $past(load));
endmodule

// File: rtl/sar_conv_sequencer.sv
// Top: successive approximation sequencer with hold/track control and
// an enforced acquisition window. Assumes an external DAC driven by
// trial_o and a comparator returning cmp_i within one step.
module sar_conv_sequencer #(
    parameter int NBITS        = 12,
    parameter int CLKS_PER_BIT = 2,
    parameter int ACQ_CLKS     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] result_o
);
    logic load, run, xfer, step_end, last_bit;
    logic [NBITS-1:0] code_next;

    sar_ctrl_fsm #(.ACQ_CLKS(ACQ_CLKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .step_end(step_end), .last_bit(last_bit),
        .load_o(load), .run_o(run), .xfer_o(xfer),
        .hold_o(hold_o), .busy_o(busy_o), .done_o(done_o)
    );

    sar_step_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(load), .run(run),
        .step_end(step_end)
    );

    sar_bit_engine #(.NBITS(NBITS)) u_bits (
        .clk(clk), .rst_n(rst_n), .load(load), .decide(step_end),
        .cmp_i(cmp_i), .trial_o(trial_o), .code_next_o(code_next),
        .last_o(last_bit)
    );

    sar_result_latch #(.NBITS(NBITS)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(xfer), .code_i(code_next),
        .result_o(result_o)
    );

    // R4
    hold_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> busy_o);
    // R5
    release_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> busy_o ##1 done_o);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hold_o && !busy_o && $past(busy_o));
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (trial_o != {1'b1, {(NBITS-1){1'b0}}}) || !hold_o || $past(trial_o) == trial_o);
endmodule

// File: tb/sim_sar_conv_sequencer.sv
// Directed bench with an ideal DAC/comparator model.
module sim_sar_conv_sequencer;
    localparam int    NB   = 12;
    localparam int    C    = 3;
    localparam int    ACQ  = 4;
    localparam longint LSB = 1000;
    localparam longint FS  = 4096 * LSB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cmp_i;
    logic hold_o, busy_o, done_o;
    logic [NB-1:0] trial_o, result_o;

    longint vin_live = 0;
    longint vin_held = 0;
    longint prev_res = 0;
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sar_conv_sequencer #(.NBITS(NB), .CLKS_PER_BIT(C), .ACQ_CLKS(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .hold_o(hold_o), .busy_o(busy_o), .done_o(done_o),
        .trial_o(trial_o), .result_o(result_o)
    );

    // Sample-and-hold and ideal comparator model.
    always_ff @(posedge clk) if (!hold_o) vin_held <= vin_live;
    always_comb cmp_i = (longint'(trial_o) * LSB) > vin_held;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One conversion; options poke start mid-conversion or during acquisition.
    task automatic convert(input longint vin, input longint vin_mid,
                           input bit poke_conv, input bit poke_acq);
        longint expc;
        expc = vin / LSB;
        if (expc > 4095) expc = 4095;
        vin_live = vin;
        start_i = 1'b1;
        step(1);
        start_i = 1'b0;
        chk("R2 hold after start", hold_o, 1);
        chk("R2 busy after start", busy_o, 1);
        chk("R10 result kept into next conversion", result_o, prev_res);
        vin_live = vin_mid;
        for (int k = 0; k < NB; k++) begin
            longint et;
            et = ((expc >> (NB - k)) << (NB - k)) | (longint'(1) << (NB - 1 - k));
            chk("R3 trial code per step", trial_o, et);
            chk("R4 hold during search", hold_o, 1);
            if (poke_conv && k == 6) start_i = 1'b1;
            step(C);
            start_i = 1'b0;
        end
        chk("R5 result at final decision", result_o, expc);
        chk("R5 hold released", hold_o, 0);
        chk("R5 busy still high", busy_o, 1);
        chk("R9 straight binary code", result_o, expc);
        step(1);
        chk("R6 busy low", busy_o, 0);
        chk("R6 done pulse", done_o, 1);
        if (poke_acq) start_i = 1'b1;
        step(1);
        chk("R6 done single cycle", done_o, 0);
        if (poke_conv) chk("R7 no queued conversion", hold_o, 0);
        step(ACQ - 1);
        start_i = 1'b0;
        if (poke_acq) begin
            chk("R8 start ignored in acquisition", hold_o, 0);
            step(3);
            chk("R8 start not queued", hold_o, 0);
            chk("R8 still idle", busy_o, 0);
            chk("R10 result held while idle", result_o, expc);
        end
        prev_res = expc;
    endtask

    initial begin
        step(3);
        chk("R1 hold in reset", hold_o, 0);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 done in reset", done_o, 0);
        chk("R1 trial in reset", trial_o, 0);
        chk("R1 result in reset", result_o, 0);
        rst_n = 1'b1;
        step(1);
        convert(0, 0, 0, 0);                    // R9 zero
        convert(999, 999, 0, 0);                // just below one LSB
        convert(1000, 1000, 0, 0);              // one LSB
        convert(1443500, 4000000, 1, 0);        // R4 input change, R7 poke
        convert(2048000, 2048000, 0, 0);        // mid scale
        convert(4095999, 4095999, 0, 0);        // top code
        convert(FS, FS, 0, 0);                  // R9 full scale clamps
        convert(5000000, 0, 0, 1);              // over range, R8 poke
        convert(2047999, 2047999, 0, 0);        // R8 boundary after idle
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule